// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Per-Character Error Flags

This block turns an asynchronous serial line into a stream of received characters. The line rests high when idle. A one-cycle enable arrives at sixteen times the bit rate, and the receiver uses it to find the start bit, sample each bit at its centre and assemble characters of 5 to 8 data bits. Each character may carry a parity bit and may end with one or two stop bits.

Every received character goes into a queue together with three flags: break, parity error and framing error. The queue is either a 16-entry FIFO or a single holding register, chosen by a mode input. A reader sees the character at the head of the queue and the flags that belong to it. A pop strobe removes the head. A clear strobe wipes the head's flags and the sticky overrun indication.

A break is a line held low for a whole frame. The receiver stores a break as one zero character and then refuses further input until the line has gone high again and a fresh, valid start bit arrives.

Top module: `uart_rx_tag`

## Requirements
- R1: After reset, rd_valid, rd_data, sts_break, sts_parity, sts_frame and sts_overrun are all 0.
- R2: A low level on rxd is taken as a start bit only if the line is still low at the 8th oversample tick after the low was first seen. A shorter low pulse produces no character.
- R3: Data bits are sampled at mid-bit, least significant bit first. The number of data bits is set by cfg_wlen: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Unused upper bits of rd_data read as 0.
- R4: When cfg_par_en is 1, a parity bit follows the data. sts_parity is set for a character whose parity bit makes the total count of ones odd when cfg_par_even is 1, or even when cfg_par_even is 0. When cfg_par_en is 0, no parity bit is expected.
- R5: sts_frame is set when the first stop bit is sampled as 0. With cfg_two_stop at 1, the second stop bit time is waited out but never checked.
- R6: If every sampled bit of a frame (start, data, parity and first stop) is low, exactly one character 0x00 is stored, with sts_break set and sts_parity and sts_frame clear.
- R7: After a break, no character is stored, however long the line stays low, until rxd has returned high and a new valid start bit follows.
- R8: With cfg_fifo_en at 1, up to 16 characters are held and read out in arrival order. The flags shown always belong to the character at the head.
- R9: A character that arrives while the queue is full is dropped, and sts_overrun becomes 1.
- R10: With cfg_fifo_en at 0, the queue holds one character. A second arrival before that character is popped is dropped and sets sts_overrun.
- R11: A one-cycle pulse on sts_clr clears the head character's break, parity and framing flags and clears sts_overrun. The character's data stays in place.
- R12: A one-cycle pulse on rd_pop while rd_valid is 1 removes the head, and the next character, if there is one, appears on rd_data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | One-cycle enable at 16x the bit rate |
| rxd | input | 1 | Serial receive line, high when idle |
| cfg_wlen | input | 2 | Data bits: 00=5, 01=6, 10=7, 11=8 |
| cfg_par_en | input | 1 | A parity bit is expected |
| cfg_par_even | input | 1 | 1 selects even parity, 0 selects odd parity |
| cfg_two_stop | input | 1 | Frames carry two stop bits |
| cfg_fifo_en | input | 1 | 1 selects the 16-entry FIFO, 0 the single holding register |
| rd_pop | input | 1 | Remove the head character |
| sts_clr | input | 1 | Clear the head flags and the overrun flag |
| rd_valid | output | 1 | The queue holds at least one character |
| rd_data | output | 8 | Head character, 0 when the queue is empty |
| sts_break | output | 1 | The head character is a break |
| sts_parity | output | 1 | The head character has a parity error |
| sts_frame | output | 1 | The head character has a framing error |
| sts_overrun | output | 1 | A character was dropped because the queue was full |

## Verification
A framer state that goes wrong moves the sampling point or the bit count. The effect shows up at the ports within the same frame: a shifted or truncated rd_data value, or a parity or framing flag that should not be there, one stop-bit time after the last data bit. A faulty break lock-out shows as an extra zero character, or a missing one, while the line is held low. Queue pointer or count errors show up only when the queue is read: characters arrive out of order, overrun appears too early or too late, or rd_valid stays high after the last pop. The bench therefore fills the queue completely and drains it.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_STOP2,
    ST_BRKWAIT
  } rx_state_e;

  typedef struct packed {
    logic              brk;
    logic              par;
    logic              frm;
    logic [DATA_W-1:0] data;
  } rx_char_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign dout = sh_q[STAGES-1];

endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       rxd_i,
  input  logic [1:0] wlen_i,
  input  logic       par_en_i,
  input  logic       par_even_i,
  input  logic       two_stop_i,
  output logic       push_o,
  output rx_char_t   char_o
);

  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  rx_state_e         state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [2:0]        bit_q, bit_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              zero_q, zero_d;
  logic              pacc_q, pacc_d;
  logic              perr_q, perr_d;

  logic [2:0] last_bit;
  logic       sample;

  assign last_bit = {1'b0, wlen_i} + 3'd4;
  assign sample   = tick_i && (cnt_q == LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    data_d  = data_q;
    zero_d  = zero_q;
    pacc_d  = pacc_q;
    perr_d  = perr_q;
    push_o  = 1'b0;
    char_o  = '0;

    if (tick_i && (state_q == ST_DATA || state_q == ST_PAR ||
                   state_q == ST_STOP || state_q == ST_STOP2)) begin
      cnt_d = sample ? '0 : cnt_q + 1'b1;
    end

    case (state_q)
      ST_IDLE: begin
        if (tick_i && !rxd_i) begin
          state_d = ST_START;
          cnt_d   = '0;
        end
      end
      ST_START: begin
        if (tick_i) begin
          if (cnt_q == MID) begin
            cnt_d = '0;
            if (!rxd_i) begin
              state_d = ST_DATA;
              bit_d   = '0;
              data_d  = '0;
              zero_d  = 1'b1;
              pacc_d  = 1'b0;
              perr_d  = 1'b0;
            end else begin
              state_d = ST_IDLE;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (sample) begin
          data_d[bit_q] = rxd_i;
          zero_d        = zero_q & ~rxd_i;
          pacc_d        = pacc_q ^ rxd_i;
          if (bit_q == last_bit) state_d = par_en_i ? ST_PAR : ST_STOP;
          else                   bit_d   = bit_q + 1'b1;
        end
      end
      ST_PAR: begin
        if (sample) begin
          perr_d  = (pacc_q ^ rxd_i) ^ ~par_even_i;
          zero_d  = zero_q & ~rxd_i;
          state_d = ST_STOP;
        end
      end
      ST_STOP: begin
        if (sample) begin
          push_o = 1'b1;
          if (zero_q && !rxd_i) begin
            char_o.brk = 1'b1;
            state_d    = ST_BRKWAIT;
          end else begin
            char_o.data = data_q;
            char_o.par  = perr_q;
            char_o.frm  = ~rxd_i;
            state_d     = two_stop_i ? ST_STOP2 : ST_IDLE;
          end
        end
      end
      ST_STOP2: begin
        if (sample) state_d = ST_IDLE;
      end
      ST_BRKWAIT: begin
        if (rxd_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      data_q  <= '0;
      zero_q  <= 1'b0;
      pacc_q  <= 1'b0;
      perr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      data_q  <= data_d;
      zero_q  <= zero_d;
      pacc_q  <= pacc_d;
      perr_q  <= perr_d;
    end
  end

  // R2: a start that is high again at mid-bit falls back to idle
  a_r2_start_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && tick_i && cnt_q == MID && rxd_i) |=> state_q == ST_IDLE);

  // R6: a stored break always enters the lock-out state
  a_r6_break_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (push_o && char_o.brk) |=> state_q == ST_BRKWAIT);

  // R7: nothing is stored while locked out
  a_r7_no_push_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BRKWAIT) |-> !push_o);

  // R5: the second stop bit time stores nothing
  a_r5_stop2_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP2) |-> !push_o);

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fifo_en_i,
  input  logic     push_i,
  input  rx_char_t char_i,
  input  logic     pop_i,
  input  logic     clr_i,
  output rx_char_t head_o,
  output logic     not_empty_o,
  output logic     overrun_o
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PTR_MAX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

  rx_char_t      mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovr_q, ovr_d;

  logic full, do_push, do_pop, ovf_set, do_clr;

  always_comb begin
    full    = fifo_en_i ? (cnt_q == CNT_MAX) : (cnt_q != '0);
    do_push = push_i && !full;
    do_pop  = pop_i && (cnt_q != '0);
    ovf_set = push_i && full;
    do_clr  = clr_i && (cnt_q != '0);

    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = (wp_q == PTR_MAX) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == PTR_MAX) ? '0 : rp_q + 1'b1;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (!do_push && do_pop) cnt_d = cnt_q - 1'b1;

    ovr_d = ovr_q;
    if (ovf_set)    ovr_d = 1'b1;
    else if (clr_i) ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      ovr_q <= ovr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= char_i;
    if (do_clr) begin
      mem_q[rp_q].brk <= 1'b0;
      mem_q[rp_q].par <= 1'b0;
      mem_q[rp_q].frm <= 1'b0;
    end
  end

  assign not_empty_o = (cnt_q != '0);
  assign head_o      = not_empty_o ? mem_q[rp_q] : '0;
  assign overrun_o   = ovr_q;

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);

  // R9 / R10: a push into a full queue changes nothing but the overrun flag
  a_r9_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full && !pop_i) |=> ($stable(cnt_q) && overrun_o));

  // R11: clear wipes the head flags and the overrun flag
  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !pop_i && !ovf_set && cnt_q != '0) |=>
      (!head_o.brk && !head_o.par && !head_o.frm && !overrun_o));

  // R12: a pop without a push lowers the count by one
  a_r12_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/uart_rx_tag.sv
module uart_rx_tag
  import uart_rx_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rxd,
  input  logic [1:0] cfg_wlen,
  input  logic       cfg_par_en,
  input  logic       cfg_par_even,
  input  logic       cfg_two_stop,
  input  logic       cfg_fifo_en,
  input  logic       rd_pop,
  input  logic       sts_clr,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       sts_break,
  output logic       sts_parity,
  output logic       sts_frame,
  output logic       sts_overrun
);

  logic     rxd_s;
  logic     push;
  rx_char_t rx_char;
  rx_char_t head;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rxd),
    .dout (rxd_s)
  );

  uart_rx_framer #(.OSR(OSR)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (os_tick),
    .rxd_i     (rxd_s),
    .wlen_i    (cfg_wlen),
    .par_en_i  (cfg_par_en),
    .par_even_i(cfg_par_even),
    .two_stop_i(cfg_two_stop),
    .push_o    (push),
    .char_o    (rx_char)
  );

  uart_rx_queue #(.DEPTH(DEPTH)) u_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_en_i  (cfg_fifo_en),
    .push_i     (push),
    .char_i     (rx_char),
    .pop_i      (rd_pop),
    .clr_i      (sts_clr),
    .head_o     (head),
    .not_empty_o(rd_valid),
    .overrun_o  (sts_overrun)
  );

  assign rd_data    = head.data;
  assign sts_break  = head.brk;
  assign sts_parity = head.par;
  assign sts_frame  = head.frm;

endmodule

// File: tb/uart_rx_tag_test.sv
module uart_rx_tag_test;

  localparam int BIT_CLKS = 64;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       os_tick;
  logic       rxd;
  logic [1:0] cfg_wlen;
  logic       cfg_par_en, cfg_par_even, cfg_two_stop, cfg_fifo_en;
  logic       rd_pop, sts_clr;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       sts_break, sts_parity, sts_frame, sts_overrun;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  uart_rx_tag uut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_two_stop(cfg_two_stop), .cfg_fifo_en(cfg_fifo_en),
    .rd_pop(rd_pop), .sts_clr(sts_clr), .rd_valid(rd_valid), .rd_data(rd_data),
    .sts_break(sts_break), .sts_parity(sts_parity), .sts_frame(sts_frame),
    .sts_overrun(sts_overrun)
  );

  initial begin
    os_tick = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      os_tick = 1'b1;
      @(negedge clk);
      os_tick = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic line_bits(input logic v, input int n);
    rxd = v;
    repeat (n * BIT_CLKS) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input int nb, input bit bad_par,
                      input logic s1, input logic s2);
    logic p;
    p = 1'b0;
    line_bits(1'b0, 1);
    for (int i = 0; i < nb; i++) begin
      line_bits(d[i], 1);
      p = p ^ d[i];
    end
    if (cfg_par_en) line_bits(p ^ ~cfg_par_even ^ bad_par, 1);
    line_bits(s1, 1);
    if (cfg_two_stop) line_bits(s2, 1);
    line_bits(1'b1, 2);
  endtask

  task automatic pop();
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear();
    sts_clr = 1'b1;
    @(negedge clk);
    sts_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 valid", rd_valid, 0);
    chk("R1 data", rd_data, 0);
    chk("R1 flags", {sts_break, sts_parity, sts_frame, sts_overrun}, 0);
  endtask

  task automatic t_glitch();
    rxd = 1'b0;
    repeat (16) @(negedge clk);
    line_bits(1'b1, 12);
    chk("R2 glitch ignored", rd_valid, 0);
  endtask

  task automatic t_wordlen();
    for (int w = 0; w < 4; w++) begin
      cfg_wlen = 2'(w);
      send(8'hB6, w + 5, 1'b0, 1'b1, 1'b1);
      chk("R3 valid", rd_valid, 1);
      chk("R3 data", rd_data, 8'hB6 & 8'((1 << (w + 5)) - 1));
      chk("R3 flags", {sts_break, sts_parity, sts_frame}, 0);
      pop();
    end
    cfg_wlen = 2'b11;
  endtask

  task automatic t_parity();
    cfg_par_en = 1'b1;
    cfg_par_even = 1'b1;
    send(8'h3C, 8, 1'b0, 1'b1, 1'b1);
    send(8'h3D, 8, 1'b1, 1'b1, 1'b1);
    cfg_par_even = 1'b0;
    send(8'h07, 8, 1'b0, 1'b1, 1'b1);
    send(8'h07, 8, 1'b1, 1'b1, 1'b1);
    chk("R8 head data", rd_data, 8'h3C);
    chk("R4 even good", sts_parity, 0);
    pop();
    chk("R8 head data", rd_data, 8'h3D);
    chk("R4 even bad", sts_parity, 1);
    pop();
    chk("R4 odd good", sts_parity, 0);
    pop();
    chk("R4 odd bad", sts_parity, 1);
    pop();
    cfg_par_en = 1'b0;
  endtask

  task automatic t_framing();
    send(8'h55, 8, 1'b0, 1'b0, 1'b1);
    chk("R5 frame error data", rd_data, 8'h55);
    chk("R5 frame error", sts_frame, 1);
    pop();
    cfg_two_stop = 1'b1;
    send(8'h66, 8, 1'b0, 1'b1, 1'b0);
    chk("R5 second stop ignored", {rd_data, sts_frame}, {8'h66, 1'b0});
    pop();
    chk("R5 single char", rd_valid, 0);
    send(8'h77, 8, 1'b0, 1'b0, 1'b1);
    chk("R5 first stop checked", sts_frame, 1);
    pop();
    cfg_two_stop = 1'b0;
  endtask

  task automatic t_break();
    line_bits(1'b0, 14);
    chk("R6 one char", rd_valid, 1);
    chk("R6 break value", {rd_data, sts_break, sts_parity, sts_frame}, {8'h00, 3'b100});
    pop();
    line_bits(1'b0, 14);
    chk("R7 locked out while low", rd_valid, 0);
    line_bits(1'b1, 2);
    chk("R7 nothing on release", rd_valid, 0);
    send(8'h5A, 8, 1'b0, 1'b1, 1'b1);
    chk("R7 resumes", {rd_valid, rd_data, sts_break}, {1'b1, 8'h5A, 1'b0});
    pop();
  endtask

  task automatic t_fifo_full();
    for (int i = 0; i < 16; i++) send(8'(i * 7 + 1), 8, 1'b0, 1'b1, 1'b1);
    chk("R9 no overrun at 16", sts_overrun, 0);
    send(8'hEE, 8, 1'b0, 1'b1, 1'b1);
    chk("R9 overrun", sts_overrun, 1);
    for (int i = 0; i < 16; i++) begin
      chk("R8 order", rd_data, 8'(i * 7 + 1));
      pop();
    end
    chk("R12 drained", rd_valid, 0);
    clear();
    chk("R11 overrun cleared", sts_overrun, 0);
  endtask

  task automatic t_clear();
    cfg_par_en = 1'b1;
    cfg_par_even = 1'b1;
    send(8'h81, 8, 1'b1, 1'b0, 1'b1);
    chk("R4 flag before clear", {sts_parity, sts_frame}, 2'b11);
    clear();
    chk("R11 flags cleared", {sts_break, sts_parity, sts_frame}, 0);
    chk("R11 data kept", {rd_valid, rd_data}, {1'b1, 8'h81});
    pop();
    cfg_par_en = 1'b0;
  endtask

  task automatic t_holding();
    cfg_fifo_en = 1'b0;
    send(8'h11, 8, 1'b0, 1'b1, 1'b1);
    chk("R10 no overrun first", sts_overrun, 0);
    send(8'h22, 8, 1'b0, 1'b1, 1'b1);
    chk("R10 overrun", sts_overrun, 1);
    chk("R10 first kept", rd_data, 8'h11);
    pop();
    chk("R10 single entry", rd_valid, 0);
    clear();
    cfg_fifo_en = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    rxd = 1'b1;
    cfg_wlen = 2'b11;
    cfg_par_en = 1'b0;
    cfg_par_even = 1'b0;
    cfg_two_stop = 1'b0;
    cfg_fifo_en = 1'b1;
    rd_pop = 1'b0;
    sts_clr = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_glitch();
    t_wordlen();
    t_parity();
    t_framing();
    t_break();
    t_fifo_full();
    t_clear();
    t_holding();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule